// File: doc/BRIEF.md
# Deep-Sleep Aware SRAM Host Controller

This block sits between a synchronous on-chip host and an external asynchronous static RAM that has an active-low deep-sleep input and a per-read single-bit-error flag. The host issues one access at a time through a valid/ready request port and receives read data on a one-cycle response strobe. The controller turns each access into chip-enable, output-enable and write-enable strobes, each lasting a whole number of clock cycles.

A level sleep request moves the memory into its low-power retention state. A wake request brings it back. The controller keeps the memory in deep sleep for the minimum pulse time and the settle time, and it remembers a wake request that arrives too early. After release it holds chip enable high and blocks all host traffic for the recovery lockout.

Each read returns the memory's error flag with the data. A saturating counter keeps a running total of flagged reads. Every time limit is given in nanoseconds and converted to clock cycles, rounded up, from the clock period parameter.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, err_cnt_o is 0, and mem_ce_no, mem_oe_no, mem_we_no and mem_ds_no are all 1.
- R2: An accepted read (req_write_i=0) holds mem_ce_no and mem_oe_no low with mem_we_no high for exactly RD cycles. rsp_valid_o is 1 for one cycle, in the cycle the strobes return high. It carries the data and error flag sampled in the last low cycle.
- R3: An accepted write (req_write_i=1) holds mem_ce_no and mem_we_no low with mem_oe_no high for exactly WR cycles. WR is the larger of the pulse and setup limits. For that whole time the address and data are driven and mem_wdata_oe_o is 1.
- R4: req_ready_o is 1 only when the controller is idle. While it is 0, a request on the input port causes no memory strobe and changes no stored word.
- R5: rsp_err_o carries the sampled mem_err_i of each read. err_cnt_o increases by one for each read with the flag set, and it saturates at its all-ones value.
- R6: A sleep request while idle drives mem_ds_no low in the next cycle. mem_ce_no stays high, and req_ready_o stays 0, for as long as mem_ds_no is low.
- R7: mem_ds_no stays low for at least HOLD cycles, the larger of the minimum pulse and the settle time. A wake request that arrives before then is remembered, and mem_ds_no rises exactly HOLD cycles after it fell.
- R8: Once the hold time has passed, a wake request raises mem_ds_no in the next cycle. After that, mem_ce_no stays high and req_ready_o stays 0 for WAKE+1 cycles before req_ready_o returns to 1.
- R9: If an access request and a sleep request are both present while idle, the access is performed and the sleep request is not taken in that cycle.
- R10: Every cycle count equals ceil(ns*1000 / CLK_PS) for its nanosecond parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_err_o | output | 1 | Error flag sampled with the read data |
| err_cnt_o | output | ERR_W | Saturating count of flagged reads |
| sleep_req_i | input | 1 | Request deep sleep (level, acted on when idle) |
| wake_req_i | input | 1 | Request wake from deep sleep |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_wdata_oe_o | output | 1 | Write data drive enable |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_err_i | input | 1 | Memory single-bit-error flag |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_ds_no | output | 1 | Deep sleep, active low |

## Verification
The bench sends a wake request in the first cycle of deep sleep. A design that acts on it at once, or that drops it, shows a deep-sleep pulse shorter than HOLD or one that never ends. The bench also counts, cycle by cycle, the wake lockout and the strobe widths of reads and writes: an off-by-one counter or a missing recovery wait changes those counts.

Requests issued during sleep must leave memory untouched, and a simultaneous sleep-and-write must still write. A design that leaks blocked requests corrupts a word that is read back later. A design that lets sleep win loses the write. The error counter is driven past its all-ones value, so a counter that wraps returns zero.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_SLEEP_ENTER, ST_SLEEP, ST_WAKE_WAIT, ST_READY
  } ctrl_state_e;

  // ceil(ns*1000/clk_ps), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    longint unsigned t;
    longint unsigned c;
    t = longint'(ns) * 64'd1000;
    c = (t + longint'(clk_ps) - 64'd1) / longint'(clk_ps);
    if (c == 0) c = 1;
    return int'(c[31:0]);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_err_counter.sv
module sram_err_counter #(
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ERR_W-1:0] cnt_o
);
  logic [ERR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_err_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + ERR_W'(1)));

  p_err_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i || cnt_q == '1) |=> $stable(cnt_q));

endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ERR_W        = 16,
  parameter int unsigned CLK_PS       = 8000,
  parameter int unsigned RD_NS        = 10,
  parameter int unsigned WR_PULSE_NS  = 7,
  parameter int unsigned WR_SETUP_NS  = 5,
  parameter int unsigned DS_MIN_NS    = 100,
  parameter int unsigned DS_SETTLE_NS = 1000000,
  parameter int unsigned WAKE_NS      = 300000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic [ERR_W-1:0]  err_cnt_o,
  input  logic              sleep_req_i,
  input  logic              wake_req_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wdata_oe_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_ds_no
);

  localparam int unsigned RD_CYC   = ns_to_cyc(RD_NS, CLK_PS);
  localparam int unsigned WR_CYC   = max2(ns_to_cyc(WR_PULSE_NS, CLK_PS), ns_to_cyc(WR_SETUP_NS, CLK_PS));
  localparam int unsigned HOLD_CYC = max2(ns_to_cyc(DS_MIN_NS, CLK_PS), ns_to_cyc(DS_SETTLE_NS, CLK_PS));
  localparam int unsigned WAKE_CYC = ns_to_cyc(WAKE_NS, CLK_PS);
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WR_CYC), max2(HOLD_CYC, WAKE_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  ctrl_state_e       state_q, state_d;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              wake_pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ce_n_q, oe_n_q, we_n_q, ds_n_q, wdata_oe_q;
  logic              rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              rd_done;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          tmr_load = 1'b1;
          if (req_write_i) begin
            state_d = ST_WRITE;
            tmr_val = CNT_W'(WR_CYC - 1);
          end else begin
            state_d = ST_READ;
            tmr_val = CNT_W'(RD_CYC - 1);
          end
        end else if (sleep_req_i) begin
          state_d  = ST_SLEEP_ENTER;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_READ, ST_WRITE: if (tmr_done) state_d = ST_IDLE;
      ST_SLEEP_ENTER: begin
        if (tmr_done) begin
          if (wake_pend_q || wake_req_i) begin
            state_d  = ST_WAKE_WAIT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WAKE_CYC - 1);
          end else begin
            state_d = ST_SLEEP;
          end
        end
      end
      ST_SLEEP: begin
        if (wake_req_i) begin
          state_d  = ST_WAKE_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WAKE_CYC - 1);
        end
      end
      ST_WAKE_WAIT: if (tmr_done) state_d = ST_READY;
      ST_READY:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  assign rd_done = (state_q == ST_READ) && tmr_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wake_pend_q <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      wake_pend_q <= (state_q == ST_SLEEP_ENTER) && (state_d == ST_SLEEP_ENTER)
                     && (wake_pend_q || wake_req_i);
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  // strobes registered from next state: glitch-free at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      we_n_q     <= 1'b1;
      ds_n_q     <= 1'b1;
      wdata_oe_q <= 1'b0;
    end else begin
      ce_n_q     <= !(state_d == ST_READ || state_d == ST_WRITE);
      oe_n_q     <= (state_d != ST_READ);
      we_n_q     <= (state_d != ST_WRITE);
      ds_n_q     <= !(state_d == ST_SLEEP_ENTER || state_d == ST_SLEEP);
      wdata_oe_q <= (state_d == ST_WRITE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rd_done;
      if (rd_done) begin
        rsp_rdata_q <= mem_rdata_i;
        rsp_err_q   <= mem_err_i;
      end
    end
  end

  sram_err_counter #(.ERR_W(ERR_W)) u_err_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rd_done && mem_err_i),
    .cnt_o  (err_cnt_o)
  );

  assign req_ready_o    = (state_q == ST_IDLE);
  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_rdata_o    = rsp_rdata_q;
  assign rsp_err_o      = rsp_err_q;
  assign mem_addr_o     = addr_q;
  assign mem_wdata_o    = wdata_q;
  assign mem_wdata_oe_o = wdata_oe_q;
  assign mem_ce_no      = ce_n_q;
  assign mem_oe_no      = oe_n_q;
  assign mem_we_no      = we_n_q;
  assign mem_ds_no      = ds_n_q;

  // deep-sleep low-time monitor for the hold check
  logic [CNT_W-1:0] ds_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ds_low_q <= '0;
    else if (ds_n_q)                      ds_low_q <= '0;
    else if (ds_low_q < CNT_W'(HOLD_CYC)) ds_low_q <= ds_low_q + 1'b1;
  end

  p_ds_ce_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ds_no |-> (mem_ce_no && !req_ready_o));

  p_ds_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ds_no) |-> (ds_low_q >= CNT_W'(HOLD_CYC)));

  p_ready_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && mem_ds_no));

  p_rsp_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_we_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && mem_wdata_oe_o && !mem_ce_no));

  p_wake_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE_WAIT) |-> (mem_ce_no && mem_ds_no && !req_ready_o));

endmodule

// File: tb/sram_sleep_ctrl_test.sv
`timescale 1ns/1ps
module sram_sleep_ctrl_test;

  localparam int AW = 4, DW = 8, EW = 2, CLK_PS = 8000;
  localparam int RD_NS = 20, WRP_NS = 12, WRS_NS = 8;
  localparam int DSMIN_NS = 100, DSSET_NS = 40, WAKE_NS = 200;

  function automatic int ceil_cyc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  // R10: expected counts from the nanosecond parameters
  localparam int E_RD   = (RD_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WR_A = (WRP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WR_B = (WRS_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WR   = (E_WR_A > E_WR_B) ? E_WR_A : E_WR_B;
  localparam int E_H_A  = (DSMIN_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int E_H_B  = (DSSET_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int E_HOLD = (E_H_A > E_H_B) ? E_H_A : E_H_B;
  localparam int E_WAKE = (WAKE_NS * 1000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [EW-1:0] err_cnt;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_wdata_oe, mem_err, ce_n, oe_n, we_n, ds_n;

  logic [DW-1:0] mem [16];
  logic flag [16];

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sram_sleep_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ERR_W(EW), .CLK_PS(CLK_PS),
    .RD_NS(RD_NS), .WR_PULSE_NS(WRP_NS), .WR_SETUP_NS(WRS_NS),
    .DS_MIN_NS(DSMIN_NS), .DS_SETTLE_NS(DSSET_NS), .WAKE_NS(WAKE_NS)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .err_cnt_o(err_cnt), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_wdata_oe_o(mem_wdata_oe),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_ds_no(ds_n)
  );

  // memory model
  always @(posedge clk) if (!we_n && !ce_n && ds_n) mem[mem_addr] <= mem_wdata;
  assign mem_rdata = (!ce_n && !oe_n) ? mem[mem_addr] : '0;
  assign mem_err   = (!ce_n && !oe_n) ? flag[mem_addr] : 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk({ce_n, oe_n, we_n, ds_n} === 4'hF, "R1 strobes in reset", int'({ce_n, oe_n, we_n, ds_n}), 15);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk(err_cnt === '0, "R1 err_cnt after reset", int'(err_cnt), 0);
    chk({ce_n, oe_n, we_n, ds_n} === 4'hF, "R1 strobes idle", int'({ce_n, oe_n, we_n, ds_n}), 15);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int cnt = 0;
    bit bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!we_n && cnt < 100) begin
      if (ce_n || !oe_n || !mem_wdata_oe || mem_wdata !== d || mem_addr !== a) bad = 1;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == E_WR, "R3 write pulse cycles", cnt, E_WR);
    chk(!bad, "R3 write strobes and data", int'(bad), 0);
    chk(req_ready === 1'b1, "R4 ready after write", int'(req_ready), 1);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic e,
                        input int exp_cnt);
    int cnt = 0;
    bit bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R4 ready low during read", int'(req_ready), 0);
    while (!oe_n && cnt < 100) begin
      if (ce_n || !we_n || rsp_valid) bad = 1;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == E_RD, "R2 read strobe cycles", cnt, E_RD);
    chk(!bad, "R2 read strobes", int'(bad), 0);
    chk(rsp_valid === 1'b1, "R2 rsp_valid", int'(rsp_valid), 1);
    chk(rsp_rdata === d, "R2 read data", int'(rsp_rdata), int'(d));
    chk(rsp_err === e, "R5 rsp_err", int'(rsp_err), int'(e));
    chk(int'(err_cnt) == exp_cnt, "R5 err_cnt", int'(err_cnt), exp_cnt);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 rsp_valid one cycle", int'(rsp_valid), 0);
  endtask

  task automatic t_errors();
    flag[7] = 1'b1;
    t_write(4'd7, 8'h77);
    t_read(4'd7, 8'h77, 1'b1, 1);
    t_read(4'd7, 8'h77, 1'b1, 2);
    t_read(4'd7, 8'h77, 1'b1, 3);
    t_read(4'd7, 8'h77, 1'b1, 3);   // R5 saturation
    t_read(4'd2, 8'hC4, 1'b0, 3);
  endtask

  task automatic t_priority();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd5; req_wdata = 8'h5A; sleep_req = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; sleep_req = 1'b0;
    chk(we_n === 1'b0, "R9 access wins: we_n", int'(we_n), 0);
    chk(ds_n === 1'b1, "R9 access wins: ds_n", int'(ds_n), 1);
    repeat (E_WR + 1) @(negedge clk);
    chk(ds_n === 1'b1 && req_ready === 1'b1, "R9 no sleep after", int'({ds_n, req_ready}), 3);
    t_read(4'd5, 8'h5A, 1'b0, 3);
  endtask

  task automatic t_sleep_early_wake();
    int cnt = 1;
    int w = 0;
    bit bad = 0;
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk(ds_n === 1'b0, "R6 ds_n falls", int'(ds_n), 0);
    chk(ce_n === 1'b1 && req_ready === 1'b0, "R6 ce high ready low", int'({ce_n, req_ready}), 2);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    while (!ds_n && cnt < 1000) begin
      if (!ce_n || req_ready) bad = 1;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == E_HOLD, "R7 early wake held to minimum", cnt, E_HOLD);
    chk(!bad, "R6 blocked while asleep", int'(bad), 0);
    bad = 0;
    while (!req_ready && w < 100000) begin
      if (!ce_n || !ds_n) bad = 1;
      w++;
      @(negedge clk);
    end
    chk(w == E_WAKE + 1, "R8 wake lockout cycles", w, E_WAKE + 1);
    chk(!bad, "R8 ce high during lockout", int'(bad), 0);
  endtask

  task automatic t_sleep_late_wake();
    int w = 0;
    bit bad = 0;
    bit leak = 0;
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    for (int i = 0; i < E_HOLD + 20; i++) begin
      if (ds_n !== 1'b0) bad = 1;
      if (i == 5) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd3; req_wdata = 8'hAA;
      end
      if (i > 5 && (we_n !== 1'b1 || req_ready !== 1'b0)) leak = 1;
      if (i == 12) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(!bad, "R6 stays asleep without wake", int'(bad), 0);
    chk(!leak, "R4 request blocked while asleep", int'(leak), 0);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk(ds_n === 1'b1, "R8 ds_n rises after wake", int'(ds_n), 1);
    while (!req_ready && w < 100000) begin
      if (!ce_n) bad = 1;
      w++;
      @(negedge clk);
    end
    chk(w == E_WAKE + 1, "R8 late wake lockout", w, E_WAKE + 1);
    chk(!bad, "R8 ce high after late wake", int'(bad), 0);
    t_read(4'd3, 8'h33, 1'b0, 3);   // R4 blocked write left no trace
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = '0;
      flag[i] = 1'b0;
    end
    chk(E_RD == ceil_cyc(RD_NS) && E_RD == 3, "R10 read cycles", E_RD, 3);
    chk(E_HOLD == 13 && E_WAKE == 25 && E_WR == 2, "R10 derived counts", E_HOLD, 13);
    t_reset();
    t_write(4'd1, 8'h11);
    t_write(4'd3, 8'h33);
    t_write(4'd2, 8'hC4);
    t_read(4'd1, 8'h11, 1'b0, 0);
    t_read(4'd3, 8'h33, 1'b0, 0);
    t_read(4'd2, 8'hC4, 1'b0, 0);
    t_errors();
    t_priority();
    t_sleep_early_wake();
    t_read(4'd1, 8'h11, 1'b0, 3);
    t_sleep_late_wake();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule